// File: doc/BRIEF.md
# Serial Memory Command Engine

This block runs one complete serial-peripheral transaction against an attached EEPROM or flash part. The host first loads a 16-byte data buffer and an address register. It then writes a command word that holds the opcode, the device select, the number of address bytes, the number of data bytes, a direction flag and an option that folds address bit 8 into the opcode. Writing the command word starts the engine. The engine selects one device, clocks out the opcode, the address and the write data, captures the returned bytes into the buffer on reads, and drops its busy flag once the device has been released.

The serial clock runs in mode 0: it idles low, the engine drives output data while the clock is low, and the engine samples input data on the rising edge. A parameter sets the length of each clock phase in system clocks. The host polls the busy flag and reads the buffer after busy falls. Breaking a transfer into several transactions is left to the host.

Top module: `spi_host_engine`

## Requirements
- R1: A command write while idle raises busy_o on the next clock. busy_o falls only after the whole frame has been sent and every select line is high again.
- R2: During a transaction only cs_no[sel] is driven low, where sel is the select field latched at start. All other select lines stay high.
- R3: The frame is the opcode, then the address bytes, then the data bytes. Every byte goes out MSB first. The address bytes are the low acnt bytes of the address register, most significant of them first. The frame is 8*(1+acnt+dcnt) clocks long, and acnt=0 sends no address.
- R4: On a write (rd=0), buf_i[7:0] is the first data byte on the wire, buf_i[15:8] is the second, and so on.
- R5: On a read (rd=1), mosi_o is low during the data phase. The byte received j-th lands in buf_o[8j+7:8j], and buffer bytes beyond the count read back as zero.
- R6: With munge=1 and acnt>0, the transmitted opcode is the base opcode with bit 3 ORed with address bit 8. With acnt=0, or with munge=0, the opcode goes out unchanged.
- R7: A data count above 16 is treated as 16.
- R8: sck_o is low whenever no device is selected. mosi_o holds steady while sck_o is high. The select line falls at least HALF_DIV clocks before the first rising clock edge.
- R9: Between two transactions every select line stays high for at least 2*HALF_DIV clocks, which is one serial clock period.
- R10: While busy, writes to the command word, the address register and the buffer are ignored. The frame in flight is unchanged, no second transaction starts, and the buffer and address keep their values.
- R11: After reset busy_o is low, sck_o is low, every select line is high and buf_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_we_i | input | 1 | Command word write strobe; starts a transaction when idle |
| cmd_op_i | input | 8 | Base opcode |
| cmd_cs_i | input | CS_W | Device select index |
| cmd_acnt_i | input | ACNT_W | Address byte count |
| cmd_dcnt_i | input | DCNT_W | Data byte count, 0 to 16 |
| cmd_rd_i | input | 1 | 1 = receive data bytes, 0 = send buffer bytes |
| cmd_munge_i | input | 1 | Fold address bit 8 into opcode bit 3 |
| adr_we_i | input | 1 | Address register write strobe |
| adr_i | input | 8*ADR_BYTES | Address value |
| buf_we_i | input | 1 | Data buffer write strobe |
| buf_i | input | 8*BUF_BYTES | Data buffer value, byte 0 in bits 7:0 |
| buf_o | output | 8*BUF_BYTES | Data buffer contents |
| busy_o | output | 1 | Transaction in progress |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the device |
| cs_no | output | CS_NUM | Active-low device selects |
| miso_i | input | 1 | Serial data from the device |

## Verification
The bench models a device that records every bit sampled on the rising clock edge and answers from a programmed byte pattern. During the opcode and address phases that device drives ones, so a capture taken outside the data phase corrupts the buffer and shows up. The frames tried are a bare opcode, a write with two address bytes on the second select, a full 16-byte read with three address bytes, a short read after a non-zero preload, and a status read. Folding is tried with address bit 8 set, with it clear, and with no address bytes, which separates a correct fold from one applied always or never. A clamped count, command/address/buffer writes during busy, and the select gap and lead time measured across back-to-back frames cover the remaining boundaries.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TRAIL,
    ST_GAP
  } eng_state_e;

  localparam logic [7:0] OP_WR_STATUS = 8'h01;
  localparam logic [7:0] OP_WRITE     = 8'h02;
  localparam logic [7:0] OP_READ      = 8'h03;
  localparam logic [7:0] OP_WR_DIS    = 8'h04;
  localparam logic [7:0] OP_RD_STATUS = 8'h05;
  localparam logic [7:0] OP_WR_EN     = 8'h06;
  localparam logic [7:0] OP_SEC_ERASE = 8'h52;
endpackage

// File: rtl/spi_eng_clkdiv.sv
module spi_eng_clkdiv #(
  parameter int HALF_DIV = 2,
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i)          cnt_q <= '0;
    else if (cnt_q == LAST)   cnt_q <= '0;
    else                      cnt_q <= cnt_q + CW'(1);
  end

  assign tick_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/spi_eng_txmux.sv
module spi_eng_txmux #(
  parameter int ADR_BYTES = 3,
  parameter int BUF_BYTES = 16,
  parameter int BIT_W     = 8,
  localparam int ACNT_W   = $clog2(ADR_BYTES + 1),
  localparam int ADR_W    = 8 * ADR_BYTES,
  localparam int BUF_W    = 8 * BUF_BYTES
) (
  input  logic [7:0]        op_i,
  input  logic [ADR_W-1:0]  adr_i,
  input  logic [BUF_W-1:0]  buf_i,
  input  logic [ACNT_W-1:0] acnt_i,
  input  logic              rd_i,
  input  logic [BIT_W-1:0]  bit_i,
  output logic              mosi_o,
  output logic              in_data_o,
  output logic [BIT_W-1:0]  dat_pos_o
);
  logic [BIT_W-1:0] byte_idx, ab, dbyte;
  logic [2:0]       bit_in;
  logic [ADR_W-1:0] adr_sh;
  logic [BUF_W-1:0] buf_sh;

  always_comb begin
    byte_idx  = bit_i >> 3;
    bit_in    = 3'd7 - bit_i[2:0];
    ab        = '0;
    dbyte     = '0;
    adr_sh    = '0;
    buf_sh    = '0;
    in_data_o = 1'b0;
    dat_pos_o = '0;
    mosi_o    = 1'b0;
    if (byte_idx == '0) begin
      mosi_o = op_i[bit_in];
    end else if (byte_idx <= BIT_W'(acnt_i)) begin
      // address bytes leave most significant first
      ab     = BIT_W'(acnt_i) - byte_idx;
      adr_sh = adr_i >> (ab << 3);
      mosi_o = adr_sh[bit_in];
    end else begin
      in_data_o = 1'b1;
      dbyte     = byte_idx - BIT_W'(acnt_i) - BIT_W'(1);
      dat_pos_o = (dbyte << 3) + BIT_W'(bit_in);
      buf_sh    = buf_i >> dat_pos_o;
      mosi_o    = !rd_i && buf_sh[0];
    end
  end
endmodule

// File: rtl/spi_eng_buf.sv
module spi_eng_buf #(
  parameter int BUF_BYTES = 16,
  parameter int BIT_W     = 8,
  localparam int BUF_W    = 8 * BUF_BYTES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [BUF_W-1:0] load_data_i,
  input  logic             clr_i,
  input  logic             cap_i,
  input  logic [BIT_W-1:0] cap_pos_i,
  input  logic             cap_bit_i,
  output logic [BUF_W-1:0] data_o
);
  logic [BUF_W-1:0] data_q;

  // buffer is cleared at read start, so captured ones can be ORed in
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                data_q <= '0;
    else if (clr_i)             data_q <= '0;
    else if (cap_i && cap_bit_i) data_q <= data_q | (BUF_W'(1) << cap_pos_i);
    else if (load_i)            data_q <= load_data_i;
  end

  assign data_o = data_q;
endmodule

// File: rtl/spi_host_engine.sv
module spi_host_engine
  import spi_eng_pkg::*;
#(
  parameter int CS_NUM    = 2,
  parameter int ADR_BYTES = 3,
  parameter int BUF_BYTES = 16,
  parameter int HALF_DIV  = 2,
  localparam int CS_W     = (CS_NUM > 1) ? $clog2(CS_NUM) : 1,
  localparam int ACNT_W   = $clog2(ADR_BYTES + 1),
  localparam int DCNT_W   = $clog2(BUF_BYTES + 1),
  localparam int ADR_W    = 8 * ADR_BYTES,
  localparam int BUF_W    = 8 * BUF_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic [7:0]        cmd_op_i,
  input  logic [CS_W-1:0]   cmd_cs_i,
  input  logic [ACNT_W-1:0] cmd_acnt_i,
  input  logic [DCNT_W-1:0] cmd_dcnt_i,
  input  logic              cmd_rd_i,
  input  logic              cmd_munge_i,
  input  logic              adr_we_i,
  input  logic [ADR_W-1:0]  adr_i,
  input  logic              buf_we_i,
  input  logic [BUF_W-1:0]  buf_i,
  output logic [BUF_W-1:0]  buf_o,
  output logic              busy_o,
  output logic              sck_o,
  output logic              mosi_o,
  output logic [CS_NUM-1:0] cs_no,
  input  logic              miso_i
);
  localparam int MAX_BITS = 8 * (1 + ADR_BYTES + BUF_BYTES);
  localparam int BIT_W    = $clog2(MAX_BITS + 1);
  localparam logic [ACNT_W-1:0] ACNT_MAX = ACNT_W'(ADR_BYTES);
  localparam logic [DCNT_W-1:0] DCNT_MAX = DCNT_W'(BUF_BYTES);

  eng_state_e        state_q;
  logic [7:0]        op_q;
  logic [CS_W-1:0]   cs_sel_q;
  logic [ACNT_W-1:0] acnt_q;
  logic              rd_q;
  logic [BIT_W-1:0]  bit_q, last_q;
  logic              sck_q, cs_act_q, gap_q;
  logic [ADR_W-1:0]  adr_q;

  logic              busy, tick, start, in_data, tx_bit, cap;
  logic [BIT_W-1:0]  dat_pos, last_c;
  logic [ACNT_W-1:0] acnt_c;
  logic [DCNT_W-1:0] dcnt_c;
  logic [7:0]        op_c;

  assign busy  = (state_q != ST_IDLE);
  assign start = cmd_we_i && !busy;

  always_comb begin
    acnt_c = (cmd_acnt_i > ACNT_MAX) ? ACNT_MAX : cmd_acnt_i;
    dcnt_c = (cmd_dcnt_i > DCNT_MAX) ? DCNT_MAX : cmd_dcnt_i;
    // small parts carry address bit 8 in opcode bit 3
    op_c   = cmd_op_i | {4'b0, cmd_munge_i && (acnt_c != '0) && adr_q[8], 3'b0};
    last_c = ((BIT_W'(1) + BIT_W'(acnt_c) + BIT_W'(dcnt_c)) << 3) - BIT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 adr_q <= '0;
    else if (adr_we_i && !busy)  adr_q <= adr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      op_q     <= '0;
      cs_sel_q <= '0;
      acnt_q   <= '0;
      rd_q     <= 1'b0;
      bit_q    <= '0;
      last_q   <= '0;
      sck_q    <= 1'b0;
      cs_act_q <= 1'b0;
      gap_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          op_q     <= op_c;
          cs_sel_q <= cmd_cs_i;
          acnt_q   <= acnt_c;
          rd_q     <= cmd_rd_i;
          last_q   <= last_c;
          bit_q    <= '0;
          sck_q    <= 1'b0;
          cs_act_q <= 1'b1;
          state_q  <= ST_LEAD;
        end
        ST_LEAD: if (tick) state_q <= ST_SHIFT;
        ST_SHIFT: if (tick) begin
          if (!sck_q) begin
            sck_q <= 1'b1;
          end else begin
            sck_q <= 1'b0;
            if (bit_q == last_q) state_q <= ST_TRAIL;
            else                 bit_q   <= bit_q + BIT_W'(1);
          end
        end
        ST_TRAIL: if (tick) begin
          cs_act_q <= 1'b0;
          gap_q    <= 1'b0;
          state_q  <= ST_GAP;
        end
        ST_GAP: if (tick) begin
          if (gap_q) state_q <= ST_IDLE;
          else       gap_q   <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  spi_eng_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .tick_o (tick)
  );

  spi_eng_txmux #(
    .ADR_BYTES (ADR_BYTES),
    .BUF_BYTES (BUF_BYTES),
    .BIT_W     (BIT_W)
  ) u_mux (
    .op_i      (op_q),
    .adr_i     (adr_q),
    .buf_i     (buf_o),
    .acnt_i    (acnt_q),
    .rd_i      (rd_q),
    .bit_i     (bit_q),
    .mosi_o    (tx_bit),
    .in_data_o (in_data),
    .dat_pos_o (dat_pos)
  );

  assign cap = (state_q == ST_SHIFT) && tick && !sck_q && rd_q && in_data;

  spi_eng_buf #(
    .BUF_BYTES (BUF_BYTES),
    .BIT_W     (BIT_W)
  ) u_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (buf_we_i && !busy),
    .load_data_i (buf_i),
    .clr_i       (start && cmd_rd_i),
    .cap_i       (cap),
    .cap_pos_i   (dat_pos),
    .cap_bit_i   (miso_i),
    .data_o      (buf_o)
  );

  assign busy_o = busy;
  assign sck_o  = sck_q;
  assign mosi_o = cs_act_q ? tx_bit : 1'b0;
  assign cs_no  = cs_act_q ? ~(CS_NUM'(1) << cs_sel_q) : '1;
endmodule

// File: rtl/spi_host_engine_chk.sv
module spi_host_engine_chk #(
  parameter int CS_NUM = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_we_i,
  input logic              busy_o,
  input logic              sck_o,
  input logic [CS_NUM-1:0] cs_no
);
  p_cs_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_no));

  p_sck_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&cs_no) |-> !sck_o);

  p_idle_deselect_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (&cs_no));

  p_start_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && cmd_we_i) |=> busy_o);

  p_sel_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !(&cs_no)) |=> ((cs_no == $past(cs_no)) || (&cs_no)));
endmodule

bind spi_host_engine spi_host_engine_chk #(.CS_NUM(CS_NUM)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cmd_we_i (cmd_we_i),
  .busy_o   (busy_o),
  .sck_o    (sck_o),
  .cs_no    (cs_no)
);

// File: tb/spi_host_engine_bench.sv
module spi_host_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_DIV   = 2;
  localparam int CS_NUM     = 2;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         cmd_we_i = 1'b0;
  logic [7:0]   cmd_op_i = '0;
  logic [0:0]   cmd_cs_i = '0;
  logic [1:0]   cmd_acnt_i = '0;
  logic [4:0]   cmd_dcnt_i = '0;
  logic         cmd_rd_i = 1'b0;
  logic         cmd_munge_i = 1'b0;
  logic         adr_we_i = 1'b0;
  logic [23:0]  adr_i = '0;
  logic         buf_we_i = 1'b0;
  logic [127:0] buf_i = '0;
  logic [127:0] buf_o;
  logic         busy_o, sck_o, mosi_o, miso_i;
  logic [1:0]   cs_no;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_host_engine #(.CS_NUM(CS_NUM), .HALF_DIV(HALF_DIV)) u_spi_host_engine (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_we_i(cmd_we_i), .cmd_op_i(cmd_op_i),
    .cmd_cs_i(cmd_cs_i), .cmd_acnt_i(cmd_acnt_i), .cmd_dcnt_i(cmd_dcnt_i),
    .cmd_rd_i(cmd_rd_i), .cmd_munge_i(cmd_munge_i), .adr_we_i(adr_we_i),
    .adr_i(adr_i), .buf_we_i(buf_we_i), .buf_i(buf_i), .buf_o(buf_o),
    .busy_o(busy_o), .sck_o(sck_o), .mosi_o(mosi_o), .cs_no(cs_no), .miso_i(miso_i)
  );

  int n_tests = 0, n_fail = 0;
  logic [255:0] rx_bits, slv_tx;
  int nbits = 0, n_fall = 0, hi_run = 0, min_gap = 1000000;
  int lead_cnt = 0, first_lead = 0, mosi_moves = 0;
  logic [1:0] cs_seen;
  bit prev_hi = 1'b1, prev_sck = 1'b0, prev_mosi = 1'b0;

  assign miso_i = slv_tx[nbits];

  // device model: sample on rising serial clock
  always @(posedge sck_o) begin
    if (!(&cs_no)) begin
      if (nbits == 0) begin
        cs_seen    = ~cs_no;
        first_lead = lead_cnt;
      end
      rx_bits[nbits] = mosi_o;
      nbits++;
    end
  end

  always @(posedge clk) begin
    if (&cs_no) begin
      hi_run++;
      lead_cnt = 0;
    end else begin
      if (prev_hi) begin
        n_fall++;
        if (n_fall > 1 && hi_run < min_gap) min_gap = hi_run;
      end
      hi_run = 0;
      if (nbits == 0) lead_cnt++;
    end
    prev_hi = &cs_no;
  end

  always @(negedge clk) begin
    if (sck_o && prev_sck && (mosi_o != prev_mosi)) mosi_moves++;
    prev_sck  = sck_o;
    prev_mosi = mosi_o;
  end

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [255:0] put_byte(input logic [255:0] v, input int p, input logic [7:0] b);
    logic [255:0] r = v;
    for (int k = 0; k < 8; k++) r[8*p+k] = b[7-k];
    return r;
  endfunction

  function automatic logic [255:0] build_frame(input logic [7:0] op, input int acnt, input int deff,
      input bit rd, input bit munge, input logic [23:0] adr, input logic [127:0] wbuf);
    logic [255:0] f = '0;
    logic [7:0] opx = op | ((munge && acnt > 0 && adr[8]) ? 8'h08 : 8'h00);
    f = put_byte(f, 0, opx);
    for (int a = 0; a < acnt; a++) f = put_byte(f, 1 + a, adr[8*(acnt-1-a) +: 8]);
    for (int j = 0; j < deff; j++) f = put_byte(f, 1 + acnt + j, rd ? 8'h00 : wbuf[8*j +: 8]);
    return f;
  endfunction

  task automatic wait_idle(input string tag);
    int w = 0;
    while (busy_o && w < 20000) begin
      @(negedge clk);
      w++;
    end
    chk(!busy_o && (&cs_no), {tag, " R1 busy clears with selects high"}, {busy_o, cs_no}, 3'b011);
  endtask

  task automatic issue_cmd(input logic [7:0] op, input int cs, input int acnt, input int dcnt,
      input bit rd, input bit munge);
    nbits = 0;
    rx_bits = '0;
    @(negedge clk);
    cmd_we_i = 1'b1; cmd_op_i = op; cmd_cs_i = cs[0:0]; cmd_acnt_i = acnt[1:0];
    cmd_dcnt_i = dcnt[4:0]; cmd_rd_i = rd; cmd_munge_i = munge;
    @(negedge clk);
    cmd_we_i = 1'b0;
  endtask

  task automatic run_txn(input string tag, input logic [7:0] op, input int cs, input int acnt,
      input int dcnt, input bit rd, input bit munge, input logic [23:0] adr, input bit wr_adr,
      input logic [127:0] wbuf, input bit wr_buf, input logic [127:0] resp);
    int deff = (dcnt > 16) ? 16 : dcnt;
    logic [255:0] exp;
    logic [127:0] exp_buf = '0;
    slv_tx = '1;
    for (int j = 0; j < deff; j++)
      for (int k = 0; k < 8; k++) slv_tx[8*(1+acnt+j)+k] = resp[8*j+7-k];
    if (wr_buf) begin
      @(negedge clk); buf_we_i = 1'b1; buf_i = wbuf;
      @(negedge clk); buf_we_i = 1'b0;
    end
    if (wr_adr) begin
      @(negedge clk); adr_we_i = 1'b1; adr_i = adr;
      @(negedge clk); adr_we_i = 1'b0;
    end
    issue_cmd(op, cs, acnt, dcnt, rd, munge);
    chk(busy_o == 1'b1, {tag, " R1 busy one clock after command"}, busy_o, 1);
    wait_idle(tag);
    exp = build_frame(op, acnt, deff, rd, munge, adr, wbuf);
    chk(nbits == 8*(1+acnt+deff), {tag, " R3/R7 frame length"}, nbits, 8*(1+acnt+deff));
    chk(rx_bits == exp, {tag, " R3 frame bits"}, rx_bits, exp);
    chk(cs_seen == (2'b01 << cs), {tag, " R2 select line"}, cs_seen, 2'b01 << cs);
    if (rd) begin
      for (int j = 0; j < deff; j++) exp_buf[8*j +: 8] = resp[8*j +: 8];
      chk(buf_o == exp_buf, {tag, " R5 received bytes"}, buf_o, exp_buf);
    end
  endtask

  task automatic t_reset;
    chk(!busy_o && !sck_o && (&cs_no) && buf_o == '0, "R11 reset state",
        {busy_o, sck_o, cs_no, buf_o}, {4'b0011, 128'h0});
  endtask

  task automatic t_bare_opcode;
    run_txn("R3 bare opcode", 8'h06, 0, 0, 0, 0, 0, 24'h0, 1, '0, 0, '0);
  endtask

  task automatic t_write;
    run_txn("R4 write", 8'h02, 1, 2, 4, 0, 0, 24'h00_3C5A, 1,
            128'h0000_0000_0000_0000_0000_0000_D4C3_B2A1, 1, '0);
  endtask

  task automatic t_reads;
    run_txn("R5 full read", 8'h03, 0, 3, 16, 1, 0, 24'h12_3456, 1, '0, 0,
            128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0);
    // preload junk: unused bytes must read back zero
    run_txn("R5 short read", 8'h03, 1, 1, 3, 1, 0, 24'h00_0077, 1, {128{1'b1}}, 1,
            128'h00_0000_0000_0000_0000_0000_0081_4224);
    run_txn("R5 status read", 8'h05, 0, 0, 1, 1, 0, 24'h00_0000, 0, '0, 0, 128'h80);
  endtask

  task automatic t_munge;
    run_txn("R6 fold bit8 set", 8'h03, 0, 1, 2, 1, 1, 24'h00_01A5, 1, '0, 0, 128'hBEEF);
    run_txn("R6 fold bit8 clear", 8'h03, 0, 1, 1, 1, 1, 24'h00_00A5, 1, '0, 0, 128'h11);
    run_txn("R6 no address no fold", 8'h05, 0, 0, 1, 1, 1, 24'h00_0100, 1, '0, 0, 128'h02);
  endtask

  task automatic t_clamp;
    run_txn("R7 count clamp", 8'h02, 0, 1, 20, 0, 0, 24'h00_0010, 1,
            128'hFFEE_DDCC_BBAA_9988_7766_5544_3322_1100, 1, '0);
  endtask

  task automatic t_busy_ignore;
    logic [127:0] w1 = 128'h0000_0000_0000_0000_0000_0000_0000_6D5C;
    logic [255:0] exp;
    int falls0;
    @(negedge clk); buf_we_i = 1'b1; buf_i = w1;
    @(negedge clk); buf_we_i = 1'b0; adr_we_i = 1'b1; adr_i = 24'h00_4321;
    @(negedge clk); adr_we_i = 1'b0;
    slv_tx = '1;
    falls0 = n_fall;
    issue_cmd(8'h02, 1, 2, 2, 0, 0);
    repeat (10) @(negedge clk);
    cmd_we_i = 1'b1; cmd_op_i = 8'h52; cmd_cs_i = 1'b0; cmd_acnt_i = 2'd3;
    adr_we_i = 1'b1; adr_i = 24'h99_8877; buf_we_i = 1'b1; buf_i = {128{1'b1}};
    @(negedge clk);
    cmd_we_i = 1'b0; adr_we_i = 1'b0; buf_we_i = 1'b0;
    wait_idle("R10 poke");
    exp = build_frame(8'h02, 2, 2, 0, 0, 24'h00_4321, w1);
    chk(rx_bits == exp && nbits == 40, "R10 frame unchanged by busy writes", rx_bits, exp);
    repeat (4) @(negedge clk);
    chk(n_fall - falls0 == 1, "R10 no second transaction", n_fall - falls0, 1);
    chk(buf_o == w1, "R10 buffer kept", buf_o, w1);
    // address write during busy was dropped: old address goes out
    run_txn("R10 address kept", 8'h03, 0, 2, 0, 1, 0, 24'h00_4321, 0, '0, 0, '0);
  endtask

  task automatic t_timing;
    chk(min_gap >= 2*HALF_DIV, "R9 deselect gap", min_gap, 2*HALF_DIV);
    chk(first_lead >= HALF_DIV, "R8 select lead", first_lead, HALF_DIV);
    chk(mosi_moves == 0, "R8 data steady while clock high", mosi_moves, 0);
    chk(!sck_o, "R8 clock idles low", sck_o, 0);
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    slv_tx = '1;
    rx_bits = '0;
    cs_seen = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    t_bare_opcode;
    t_write;
    t_reads;
    t_munge;
    t_clamp;
    t_busy_ignore;
    t_timing;
    finish_run;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    finish_run;
  end
endmodule